// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small programmable sum-of-products device. Product terms arrive already formed by the AND array. The cell ORs a selected group of them and applies a programmable polarity. It then either drives the result straight to the pin or passes it through a D flip-flop clocked by the device-wide clock. The cell also returns a feedback bit to the AND array.

Two device-wide mode bits choose one of three operating modes, which apply to every cell. Two per-cell bits set the pin direction and the output polarity. Together these four bits decide three things: whether the last product term serves as the cell's output enable, whether the register is in the path, and whether the pin is only an input. The register clears asynchronously at power-up. A test path can force the register to any value on a clock edge.

There is no streaming data path. Every port is a plain level control or data pin, and no valid/ready handshake or back-pressure applies.

Top module: `plc_macrocell`

## Requirements
- R1: The device-wide mode pair (`glb_mode_a`, `glb_mode_b`) decodes as follows: (0,1) is registered mode, (1,1) is complex mode and (1,0) is simple mode. The unassigned pair (0,0) keeps the pin undriven (`pin_oe`=0), and `fb_out` then follows `pin_in`.
- R2: For every combinational configuration, `pin_out` equals the selected OR sum when `cell_pol`=1 and its complement when `cell_pol`=0.
- R3: In registered mode with `cell_io`=0, each rising clock edge without preload stores a value such that `pin_out` then equals the OR of all eight terms when `cell_pol`=1, or its complement when `cell_pol`=0. In this configuration `pin_oe` equals the inverse of the active-low `oe_pin_n`.
- R4: In registered mode with `cell_io`=1, and in complex mode whatever `cell_io` is, the data sum is the OR of terms 0 to 6 only, and term 7 alone drives `pin_oe`.
- R5: In simple mode with `cell_io`=0, the data sum is the OR of all eight terms and `pin_oe` is held at 1.
- R6: In simple mode with `cell_io`=1, `pin_oe` is 0 and `fb_out` equals `pin_in`.
- R7: A combinational cell feeds back the driven `pin_out` when `pin_oe`=1 and `pin_in` when `pin_oe`=0. A registered cell feeds back the register's pin level even while `pin_oe`=0.
- R8: Setting bit i of `pt_off` makes term i count as 0, both in the data sums and as the enable term.
- R9: Asserting `rst_n` low clears the register asynchronously. A registered-output cell then shows `pin_out`=1 for both polarities.
- R10: With `pl_en`=1 at a rising clock edge, the register loads `pl_val` in place of the normal D input, in any mode. In registered-output configuration `pin_out` then shows the complement of `pl_val`.
- R11: `oe_pin_n` has no effect on a cell that is not a registered output. For example, a combinational cell in registered mode keeps `pin_oe` equal to term 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device-wide register clock |
| rst_n | input | 1 | Active-low asynchronous power-up clear |
| glb_mode_a | input | 1 | Device-wide mode bit A |
| glb_mode_b | input | 1 | Device-wide mode bit B |
| cell_io | input | 1 | Per-cell direction/function select |
| cell_pol | input | 1 | Per-cell polarity: 1 active-high, 0 active-low |
| pt_in | input | NUM_PT | Product-term values from the AND array |
| pt_off | input | NUM_PT | Per-term disable mask |
| oe_pin_n | input | 1 | Device-wide active-low output-enable pin |
| pl_en | input | 1 | Synchronous register preload request |
| pl_val | input | 1 | Value loaded into the register on preload |
| pin_in | input | 1 | Level seen on the pad when the cell is not driving it |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback bit returned to the AND array |

## Verification
Two functions can fall in the same cycle: a preload request and the ordinary capture of the OR sum. The bench sets up product terms whose sum would store the opposite of `pl_val`, raises `pl_en` before the same edge, and checks that the pin shows the preload value. A second pairing is an asynchronous clear that lands while the register holds a preloaded 1. The bench lowers `rst_n` between clock edges and samples the pin before the next edge, expecting 1. The combinational configurations are then swept over the legal mode, direction and polarity bits against a reference model kept in the bench.

// File: rtl/plc_macrocell_pkg.sv
package plc_macrocell_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_REG  = 2'd1,
    MODE_CPX  = 2'd2,
    MODE_SMP  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OE_OFF   = 2'd0,
    OE_ON    = 2'd1,
    OE_TERM  = 2'd2,
    OE_SHARE = 2'd3
  } oe_sel_e;

  typedef struct packed {
    logic    use_reg;
    logic    full_sum;
    oe_sel_e oe_sel;
  } cell_ctl_t;

  function automatic mode_e mode_of(input logic a, input logic b);
    case ({a, b})
      2'b01:   return MODE_REG;
      2'b11:   return MODE_CPX;
      2'b10:   return MODE_SMP;
      default: return MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/plc_cell_decode.sv
module plc_cell_decode
  import plc_macrocell_pkg::*;
(
  input  logic      glb_mode_a,
  input  logic      glb_mode_b,
  input  logic      cell_io,
  output mode_e     mode,
  output cell_ctl_t ctl
);

  assign mode = mode_of(glb_mode_a, glb_mode_b);

  always_comb begin
    ctl = '{use_reg: 1'b0, full_sum: 1'b1, oe_sel: OE_OFF};
    case (mode)
      MODE_REG: begin
        ctl.use_reg  = ~cell_io;
        ctl.full_sum = ~cell_io;
        ctl.oe_sel   = cell_io ? OE_TERM : OE_SHARE;
      end
      MODE_CPX: begin
        ctl.full_sum = 1'b0;
        ctl.oe_sel   = OE_TERM;
      end
      MODE_SMP: begin
        ctl.oe_sel = cell_io ? OE_OFF : OE_ON;
      end
      default: ctl.oe_sel = OE_OFF;
    endcase
  end

endmodule

// File: rtl/plc_term_sum.sv
module plc_term_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pt_in,
  input  logic [NUM_PT-1:0] pt_off,
  output logic              sum_all,
  output logic              sum_data,
  output logic              oe_term
);

  localparam int DATA_PT = NUM_PT - 1;

  logic [NUM_PT-1:0] live;

  for (genvar gi = 0; gi < NUM_PT; gi++) begin : g_mask
    assign live[gi] = pt_in[gi] & ~pt_off[gi];
  end

  assign sum_all  = |live;
  assign sum_data = |live[DATA_PT-1:0];
  assign oe_term  = live[DATA_PT];

endmodule

// File: rtl/plc_cell_reg.sv
module plc_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic pl_en,
  input  logic pl_val,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (pl_en) q <= pl_val;
    else            q <= d;
  end

  // R10: preload beats the normal D input
  a_r10_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pl_en |=> (q == $past(pl_val)));

endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell
  import plc_macrocell_pkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_mode_a,
  input  logic              glb_mode_b,
  input  logic              cell_io,
  input  logic              cell_pol,
  input  logic [NUM_PT-1:0] pt_in,
  input  logic [NUM_PT-1:0] pt_off,
  input  logic              oe_pin_n,
  input  logic              pl_en,
  input  logic              pl_val,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb_out
);

  mode_e     mode;
  cell_ctl_t ctl;
  logic      sum_all, sum_data, oe_term;
  logic      sum_sel, comb_val, reg_d, reg_q;

  plc_cell_decode u_decode (
    .glb_mode_a (glb_mode_a),
    .glb_mode_b (glb_mode_b),
    .cell_io    (cell_io),
    .mode       (mode),
    .ctl        (ctl)
  );

  plc_term_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pt_in    (pt_in),
    .pt_off   (pt_off),
    .sum_all  (sum_all),
    .sum_data (sum_data),
    .oe_term  (oe_term)
  );

  // The register stores the inverse of the pin level, so a cleared
  // register shows a high pin whatever the polarity.
  assign reg_d = sum_all ^ cell_pol;

  plc_cell_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (reg_d),
    .pl_en  (pl_en),
    .pl_val (pl_val),
    .q      (reg_q)
  );

  assign sum_sel  = ctl.full_sum ? sum_all : sum_data;
  assign comb_val = cell_pol ? sum_sel : ~sum_sel;
  assign pin_out  = ctl.use_reg ? ~reg_q : comb_val;

  always_comb begin
    case (ctl.oe_sel)
      OE_ON:    pin_oe = 1'b1;
      OE_TERM:  pin_oe = oe_term;
      OE_SHARE: pin_oe = ~oe_pin_n;
      default:  pin_oe = 1'b0;
    endcase
  end

  assign fb_out = ctl.use_reg ? ~reg_q : (pin_oe ? pin_out : pin_in);

  logic cfg_reg_out;
  assign cfg_reg_out = (mode == MODE_REG) && !cell_io;

  // R3: pin level after an edge follows the polarity-adjusted full sum
  a_r3_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg_out && !pl_en) |=>
      (!cfg_reg_out || pin_out == ($past(cell_pol) ? $past(sum_all) : !$past(sum_all))));

  // R6: a dedicated-input cell never drives and echoes the pad
  a_r6_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SMP && cell_io) |-> (!pin_oe && fb_out == pin_in));

  // R8: a disabled enable term never turns the driver on
  a_r8_masked_oe: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_CPX || (mode == MODE_REG && cell_io)) && pt_off[NUM_PT-1]) |-> !pin_oe);

  // R1: the unassigned mode pair keeps the pad undriven
  a_r1_unassigned_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_mode_a && !glb_mode_b) |-> !pin_oe);

endmodule

// File: tb/plc_macrocell_bench.sv
`timescale 1ns/1ps
module plc_macrocell_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ga = 1'b0, gb = 1'b1, io = 1'b0, pol = 1'b0;
  logic [7:0] pt = 8'h00, off = 8'h00;
  logic       oen = 1'b0, ple = 1'b0, plv = 1'b0, pin = 1'b0;
  logic       pout, poe, fb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  plc_macrocell #(.NUM_PT(8)) u_plc_macrocell (
    .clk (clk), .rst_n (rst_n), .glb_mode_a (ga), .glb_mode_b (gb),
    .cell_io (io), .cell_pol (pol), .pt_in (pt), .pt_off (off),
    .oe_pin_n (oen), .pl_en (ple), .pl_val (plv), .pin_in (pin),
    .pin_out (pout), .pin_oe (poe), .fb_out (fb)
  );

  typedef struct packed {
    logic a, b, io, pol;
    logic [7:0] pt, off;
    logic pin, oen;
    logic eo, eoe, efb;
  } vec_t;

  localparam vec_t TBL [0:12] = '{
    '{1'b1,1'b0,1'b0,1'b1,8'h01,8'h00,1'b0,1'b1, 1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,8'h01,8'h00,1'b0,1'b1, 1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,8'h80,8'h00,1'b0,1'b1, 1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,8'h80,8'h80,1'b0,1'b1, 1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b1,1'b1, 1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,8'h80,8'h00,1'b0,1'b1, 1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,8'hC0,8'h00,1'b0,1'b1, 1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,8'h40,8'h00,1'b1,1'b1, 1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,8'hC0,8'h80,1'b0,1'b1, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,8'h81,8'h00,1'b0,1'b1, 1'b1,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,8'h01,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,8'hFF,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R5 R2";
      2:       return "R5";
      3, 9:    return "R8";
      4, 5:    return "R6";
      6, 7, 8: return "R4 R7";
      10, 11:  return "R11 R4";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model for combinational configurations: {out, oe, fb}
  function automatic logic [2:0] ref_cell(input logic a, input logic b, input logic ci,
      input logic p, input logic [7:0] t_in, input logic [7:0] t_off, input logic pi);
    logic [7:0] t;
    logic v, e, o;
    t = t_in & ~t_off;
    if (b) begin
      v = |t[6:0];
      e = t[7];
    end else if (a) begin
      v = |t;
      e = !ci;
    end else begin
      v = |t;
      e = 1'b0;
    end
    o = p ? v : !v;
    return {o, e, e ? o : pi};
  endfunction

  task automatic set_reg_cfg(input logic p);
    ga = 1'b0; gb = 1'b1; io = 1'b0; pol = p;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state, R9
    set_reg_cfg(1'b0); oen = 1'b0; off = 8'h00; pt = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 pin high pol0", pout, 1'b1);
    chk("R3 shared oe", poe, 1'b1);
    pol = 1'b1; #1;
    chk("R9 pin high pol1", pout, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // table of combinational vectors
    for (int i = 0; i < 13; i++) begin
      ga = TBL[i].a; gb = TBL[i].b; io = TBL[i].io; pol = TBL[i].pol;
      pt = TBL[i].pt; off = TBL[i].off; pin = TBL[i].pin; oen = TBL[i].oen;
      #1;
      chk({tag_of(i), " oe"}, poe, TBL[i].eoe);
      chk({tag_of(i), " fb"}, fb, TBL[i].efb);
      if (TBL[i].eoe) chk({tag_of(i), " out"}, pout, TBL[i].eo);
    end

    // registered output, R3 / R7
    @(negedge clk); set_reg_cfg(1'b1); oen = 1'b0; off = 8'h00; pt = 8'h01;
    @(negedge clk); chk("R3 pol1 sum1", pout, 1'b1); chk("R7 reg fb", fb, 1'b1);
    pt = 8'h00;
    @(negedge clk); chk("R3 pol1 sum0", pout, 1'b0); chk("R7 reg fb", fb, 1'b0);
    pol = 1'b0; pt = 8'h01;
    @(negedge clk); chk("R3 pol0 sum1", pout, 1'b0);
    pt = 8'h02; off = 8'h02;
    @(negedge clk); chk("R3 R8 pol0 masked", pout, 1'b1);
    oen = 1'b1; pin = 1'b0; #1;
    chk("R3 shared oe off", poe, 1'b0);
    chk("R7 reg fb while undriven", fb, 1'b1);

    // preload against an opposite D, R10
    oen = 1'b0; off = 8'h00;
    @(negedge clk); pol = 1'b1; pt = 8'hFF; ple = 1'b1; plv = 1'b1;
    @(negedge clk); chk("R10 preload 1 beats D", pout, 1'b0);
    pt = 8'h00; plv = 1'b0;
    @(negedge clk); chk("R10 preload 0 beats D", pout, 1'b1);
    ple = 1'b0;
    @(negedge clk); chk("R3 after preload", pout, 1'b0);

    // preload in simple mode, seen after switching to registered mode
    ga = 1'b1; gb = 1'b0; io = 1'b0; ple = 1'b1; plv = 1'b1; pt = 8'h00;
    @(negedge clk); ple = 1'b0; set_reg_cfg(1'b1); #0.5;
    chk("R10 preload in simple mode", pout, 1'b0);

    // asynchronous clear between edges, R9
    #0.5 rst_n = 1'b0; #0.5;
    chk("R9 async clear", pout, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // exhaustive sweep of combinational configurations, R1 R2 R4 R5 R6 R7 R8 R11
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 6; p++) begin
        for (int m = 0; m < 2; m++) begin
          for (int q = 0; q < 2; q++) begin
            logic [2:0] e;
            logic [7:0] pat;
            if (c[3:2] == 2'b01 && !c[1]) continue;
            case (p)
              0: pat = 8'h00; 1: pat = 8'h01; 2: pat = 8'h40;
              3: pat = 8'h80; 4: pat = 8'hC1; default: pat = 8'hFF;
            endcase
            ga = c[3]; gb = c[2]; io = c[1]; pol = c[0];
            pt = pat; off = m[0] ? 8'h80 : 8'h00; pin = q[0]; oen = q[0];
            #1;
            e = ref_cell(ga, gb, io, pol, pt, off, pin);
            chk("R2 R4 R5 R6 sweep oe", poe, e[1]);
            chk("R7 R11 sweep fb", fb, e[0]);
            if (e[1]) chk("R2 R8 sweep out", pout, e[2]);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule